// File: doc/BRIEF.md
# SDRAM Row Boundary Decoder

This block turns a physical address into a chip-select choice among four SDRAM rows. Each row owns one 8-bit boundary register, and that register holds the cumulative top of the row. The boundary value is taken as address bits 31:24, so one step is 16 MB. Row 0 begins at address zero. Every later row begins where the row before it ends and runs up to just below its own limit. A row whose boundary repeats the one below it is therefore empty: it claims no addresses and reports itself as unpopulated.

Software programs the boundaries through a byte-wide register port, one register per offset from 0 to 3. The address decode is purely combinational. The block drives a one-hot row select and a flag for addresses that lie past the last boundary. It also drives one populated flag per row, so a memory controller can skip rows that have no devices fitted. Normal programming keeps the boundaries non-decreasing. If they are not, the decoder still picks a single row by a fixed priority.

Top module: `sdram_row_decoder`

## Requirements
- R1: After reset every boundary register reads 0, every populated flag is 0 and every address raises the out-of-range flag with no row selected.
- R2: A write with regWrEn high at offset k (0..3) replaces boundary register k with regWrData at the next rising clock edge and leaves the other three unchanged. regRdData shows the register at regAddr combinationally, so it still shows the old value before that edge.
- R3: Row 0 (rowSel bit 0) is selected for addresses from 0 up to, but not including, boundary0 × 2^24.
- R4: Row i for i = 1..3 (rowSel bit i) is selected for addresses from boundary(i-1) × 2^24 up to, but not including, boundary(i) × 2^24.
- R5: A row whose boundary equals the previous boundary (boundary0 equal to 0 for row 0) is never selected.
- R6: rowPopulated bit i is 1 exactly when boundary i is greater than the previous boundary, where the previous boundary for row 0 is 0.
- R7: An address at or above boundary3 × 2^24 sets outOfRange and selects no row, whatever the other registers hold.
- R8: When the boundaries are not non-decreasing and more than one row range holds the address, the lowest-numbered such row is selected.
- R9: At most one bit of rowSel is set at any time.
- R10: rowSel and outOfRange follow a change of addr within the same clock cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boundary registers |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe of the register port |
| regAddr | input | 2 | Register offset, 0..3, selecting a row boundary |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Boundary register at regAddr |
| addr | input | 32 | Physical address to decode |
| rowSel | output | 4 | One-hot row select, bit i for row i |
| outOfRange | output | 1 | Address is at or above the last boundary |
| rowPopulated | output | 4 | Bit i set when row i covers at least 16 MB |

## Verification
The bench sweeps all 256 values of the upper address byte under six boundary settings, each with the lower 24 bits all zero and all ones. This hits every boundary from both sides. If a design compared with `<=` instead of `<`, it would claim the first 16 MB of the next row. If it ignored the lower bits, the all-ones pattern would show it. The settings include the all-zero reset state, repeated boundaries that form empty rows, a single populated top row and a limit of 255. A design that did not treat repeated boundaries as empty would select or flag a zero-size row. One setting is deliberately non-monotonic. A design with the wrong priority would pick a higher row there, or would select a row above the last boundary instead of flagging it. Each write is checked just before and just after its clock edge, which catches a register that takes the data early or late or that disturbs a neighbouring register.

// File: rtl/sdram_row_decoder_pkg.sv
package sdram_row_decoder_pkg;
  localparam int ROW_NUM = 4;
  localparam int BND_W   = 8;
  localparam int IDX_W   = $clog2(ROW_NUM);

  typedef struct packed {
    logic [ROW_NUM-1:0] wrStrobe;
    logic [BND_W-1:0]   wrData;
    logic [IDX_W-1:0]   rdIdx;
  } regCtrl_t;
endpackage

// File: rtl/sdram_row_ctrl.sv
module sdram_row_ctrl
  import sdram_row_decoder_pkg::*;
(
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regAddr,
  input  logic [BND_W-1:0] regWrData,
  output regCtrl_t         ctrl
);
  always_comb begin
    ctrl.wrStrobe = '0;
    for (int i = 0; i < ROW_NUM; i++) begin
      if (regWrEn && (regAddr == IDX_W'(i))) ctrl.wrStrobe[i] = 1'b1;
    end
    ctrl.wrData = regWrData;
    ctrl.rdIdx  = regAddr;
  end
endmodule

// File: rtl/sdram_row_datapath.sv
module sdram_row_datapath
  import sdram_row_decoder_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regCtrl_t           ctrl,
  input  logic [ADDR_W-1:0]  addr,
  output logic [BND_W-1:0]   rdData,
  output logic [ROW_NUM-1:0] rowSel,
  output logic               outOfRange,
  output logic [ROW_NUM-1:0] rowPopulated
);
  localparam int SHIFT = ADDR_W - BND_W;

  logic [BND_W-1:0]   bound    [ROW_NUM];
  logic [BND_W-1:0]   lowBound [ROW_NUM];
  logic [ADDR_W-1:0]  topAddr  [ROW_NUM];
  logic [ADDR_W-1:0]  baseAddr [ROW_NUM];
  logic [ROW_NUM-1:0] rowHit;

  for (genvar i = 0; i < ROW_NUM; i++) begin : gRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  bound[i] <= '0;
      else if (ctrl.wrStrobe[i])  bound[i] <= ctrl.wrData;
    end

    if (i == 0) begin : gFirst
      assign lowBound[i] = '0;
    end else begin : gNext
      assign lowBound[i] = bound[i-1];
    end

    assign topAddr[i]      = ADDR_W'(bound[i]) << SHIFT;
    assign baseAddr[i]     = ADDR_W'(lowBound[i]) << SHIFT;
    assign rowHit[i]       = (addr >= baseAddr[i]) && (addr < topAddr[i]);
    assign rowPopulated[i] = bound[i] > lowBound[i];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.wrStrobe[i] |=> (bound[i] == $past(ctrl.wrData))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.wrStrobe[i] |=> $stable(bound[i])); // R2
    AST_EMPTY_UNSEL: assert property (@(posedge clk) disable iff (!rstN)
      rowSel[i] |-> rowPopulated[i]); // R5
  end

  assign outOfRange = addr >= topAddr[ROW_NUM-1];

  always_comb begin
    logic found;
    found  = 1'b0;
    rowSel = '0;
    for (int i = 0; i < ROW_NUM; i++) begin
      if (!found && rowHit[i] && !outOfRange) begin
        rowSel[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign rdData = bound[ctrl.rdIdx];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel)); // R9
  AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> (rowSel == '0)); // R7
endmodule

// File: rtl/sdram_row_decoder.sv
module sdram_row_decoder
  import sdram_row_decoder_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [IDX_W-1:0]   regAddr,
  input  logic [BND_W-1:0]   regWrData,
  output logic [BND_W-1:0]   regRdData,
  input  logic [ADDR_W-1:0]  addr,
  output logic [ROW_NUM-1:0] rowSel,
  output logic               outOfRange,
  output logic [ROW_NUM-1:0] rowPopulated
);
  regCtrl_t ctrl;

  sdram_row_ctrl uCtrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .ctrl      (ctrl)
  );

  sdram_row_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .addr         (addr),
    .rdData       (regRdData),
    .rowSel       (rowSel),
    .outOfRange   (outOfRange),
    .rowPopulated (rowPopulated)
  );
endmodule

// File: tb/sdram_row_decoder_test.sv
module sdram_row_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [31:0] addr = '0;
  logic [3:0]  rowSel;
  logic        outOfRange;
  logic [3:0]  rowPopulated;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [4];

  always #4 clk = ~clk;

  sdram_row_decoder uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .addr(addr),
    .rowSel(rowSel), .outOfRange(outOfRange), .rowPopulated(rowPopulated)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, addr);
    end
  endtask

  // R2: write lands at the next edge, readback is combinational
  task automatic wrReg(input int idx, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(idx); regWrData = val;
    #1 check("R2 before edge", {24'h0, regRdData}, {24'h0, model[idx]});
    @(negedge clk);
    regWrEn = 1'b0;
    model[idx] = val;
    #1 check("R2 after edge", {24'h0, regRdData}, {24'h0, val});
  endtask

  task automatic loadCfg(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3);
    wrReg(0, b0); wrReg(1, b1); wrReg(2, b2); wrReg(3, b3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); regAddr = 2'(k);
      #1 check("R2 others kept", {24'h0, regRdData}, {24'h0, model[k]});
    end
  endtask

  task automatic sweep(input bit nonMono);
    logic [3:0] expPop;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] lo;
      lo = (i == 0) ? 8'd0 : model[i-1];
      expPop[i] = model[i] > lo;
    end
    check("R6 populated", {28'h0, rowPopulated}, {28'h0, expPop});
    for (int p = 0; p < 2; p++) begin
      for (int hi = 0; hi < 256; hi++) begin
        logic [3:0] expSel;
        logic       expOor;
        bit         found;
        string      tag;
        expOor = hi >= int'(model[3]);
        expSel = '0; found = 0; tag = "R3";
        if (!expOor) begin
          for (int i = 0; i < 4; i++) begin
            int lo;
            lo = (i == 0) ? 0 : int'(model[i-1]);
            if (!found && hi >= lo && hi < int'(model[i])) begin
              expSel[i] = 1'b1; found = 1;
              tag = (i == 0) ? "R3" : "R4";
            end
          end
        end
        if (expOor) tag = "R7";
        else if (nonMono) tag = "R8";
        @(negedge clk);
        addr = {8'(hi), (p == 0) ? 24'h000000 : 24'hFFFFFF};
        // R10: sampled 1 ns after the address change, no edge in between
        #1;
        check({tag, " R10 sel"}, {27'h0, outOfRange, rowSel}, {27'h0, expOor, expSel});
        check("R9 onehot", 32'($countones(rowSel) <= 1), 32'd1);
        for (int i = 0; i < 4; i++)
          if (!expPop[i] && rowSel[i]) check("R5 empty selected", 32'd1, 32'd0);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); regAddr = 2'(k);
      #1 check("R1 reg zero", {24'h0, regRdData}, 32'h0);
    end
    check("R1 unpopulated", {28'h0, rowPopulated}, 32'h0);
    sweep(0);
    loadCfg(8'd2, 8'd6, 8'd22, 8'd54);   sweep(0);
    loadCfg(8'd4, 8'd4, 8'd20, 8'd20);   sweep(0); // R5 empty rows 1 and 3
    loadCfg(8'd16, 8'd48, 8'd112, 8'd255); sweep(0);
    loadCfg(8'd0, 8'd0, 8'd0, 8'd8);     sweep(0); // R5 only row 3
    loadCfg(8'd40, 8'd10, 8'd80, 8'd60); sweep(1); // R8 non-monotonic
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule